// File: doc/BRIEF.md
# Nonvolatile Copy Sequence Controller

This block sits beside an SRAM-style memory port that has a nonvolatile shadow array. It watches the chip-enable strobes of ordinary read accesses and looks for an unlock pattern of six reads. The first five reads must hit fixed prefix addresses in a fixed order. The sixth read selects the operation: one address requests a copy of the SRAM into the nonvolatile array (store), and another requests the reverse copy (recall). Each access counts as one step when chip enable rises again at the end of a low pulse that lasted long enough. The output-enable strobe has no effect on the pattern, so it does not enter the block.

When a pattern completes, the block emits a one-cycle start pulse for the chosen operation. It then holds a busy flag for a fixed number of clock cycles, set separately for each operation. During that time it ignores all bus activity and keeps the data outputs disabled. A drop of the supply-good flag ends a store early, but a recall always runs to the end. After reset the block waits with the outputs disabled until the supply is first reported good. It then runs one recall on its own. The seven addresses and both durations are parameters.

Top module: `nvsc_ctrl`

## Requirements
- R1: A read step is a chip-enable low pulse that is sampled low on at least MIN_LOW consecutive clock edges, with we_n sampled high on every one of them. The address is taken on the first edge that samples ce_n low. The step is counted on the edge that first samples ce_n high again, and pulses longer than the minimum count as well.
- R2: The five prefix addresses read in order, followed by the store address, give store_start high for exactly one cycle, right after the edge that counts the sixth step. The same prefix followed by the recall address gives recall_start in the same way. The two pulses are never high together.
- R3: If the sixth read matches neither the store address nor the recall address, no pulse is issued and the pattern is discarded. A following complete pattern still works.
- R4: A read of any address other than the expected next one sends the detector back to the start. If that address equals the first prefix address, it counts as step one.
- R5: A read that repeats the address of the step just counted sends the detector back to the start and does not count as a step.
- R6: A qualifying pulse with we_n sampled low on any of its edges is a write. A write sends the detector back to the start.
- R7: A chip-enable pulse with fewer than MIN_LOW low samples is ignored and leaves the detector where it was.
- R8: busy rises in the same cycle as the start pulse. Unless the operation is aborted, busy stays high for exactly STORE_CYC cycles after a store start and RECALL_CYC cycles after a recall start.
- R9: While busy is high, bus accesses start nothing. When busy falls, the detector is back at the start.
- R10: supply_ok sampled low during a store clears busy in the next cycle. supply_ok low during a recall has no effect on its length.
- R11: After reset, busy stays low, dq_disable stays high and patterns are ignored until supply_ok is first sampled high. The next cycle then shows recall_start, followed by a recall of RECALL_CYC cycles.
- R12: dq_disable is high whenever busy is high and during the wait for power-up. It is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which the bus strobes are sampled |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Memory address bus |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| supply_ok | input | 1 | High while the supply is above the safe threshold |
| store_start | output | 1 | One-cycle pulse that starts a store |
| recall_start | output | 1 | One-cycle pulse that starts a recall |
| busy | output | 1 | High while a store or recall is running |
| dq_disable | output | 1 | High while the data outputs must stay in high impedance |

## Verification
The hardest situation to reach is a detector that has been left partway through a pattern. From the ports this looks the same as an idle detector until a later read shows the difference. The bench therefore follows every break (mismatch, repeat, write, short pulse, or accesses during a busy period) with the rest of a pattern, or with just the final address. Whether a start pulse then appears shows which step the detector was on. The sixth address is swept over the whole address space of a 4-bit configuration, and each prefix position is broken in turn. A recall is started with the supply already low, to show that the abort applies to stores only.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;
    typedef enum logic [1:0] {
        MD_PWR_WAIT = 2'd0,
        MD_IDLE     = 2'd1,
        MD_STORE    = 2'd2,
        MD_RECALL   = 2'd3
    } md_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2
    } ev_e;
endpackage

// File: rtl/nvsc_pulse.sv
// Qualifies chip-enable low pulses and classifies them when ce_n rises.
module nvsc_pulse
    import nvsc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int MIN_LOW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output ev_e           ev,
    output logic [AW-1:0] ev_addr
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(MIN_LOW);

    typedef struct packed {
        logic          ce_prev;
        logic [LW-1:0] low_cnt;
        logic          we_bad;
        logic [AW-1:0] addr;
    } pq_t;

    pq_t pq_d, pq_q;

    always_comb begin
        pq_d         = pq_q;
        ev           = EV_NONE;
        pq_d.ce_prev = ce_n;
        if (!ce_n) begin
            if (pq_q.ce_prev) begin
                // first low sample of a new pulse
                pq_d.low_cnt = LW'(1);
                pq_d.we_bad  = !we_n;
                pq_d.addr    = addr;
            end else begin
                if (pq_q.low_cnt != LOW_SAT) begin
                    pq_d.low_cnt = pq_q.low_cnt + LW'(1);
                end
                pq_d.we_bad = pq_q.we_bad | !we_n;
            end
        end else if (!pq_q.ce_prev && pq_q.low_cnt == LOW_SAT) begin
            ev = pq_q.we_bad ? EV_WRITE : EV_READ;
        end
    end

    assign ev_addr = pq_q.addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq_q <= '{ce_prev: 1'b1, low_cnt: '0, we_bad: 1'b0, addr: '0};
        end else begin
            pq_q <= pq_d;
        end
    end
endmodule

// File: rtl/nvsc_match.sv
// Six-step address pattern detector.
module nvsc_match
    import nvsc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] A1       = '0,
    parameter logic [AW-1:0] A2       = '0,
    parameter logic [AW-1:0] A3       = '0,
    parameter logic [AW-1:0] A4       = '0,
    parameter logic [AW-1:0] A5       = '0,
    parameter logic [AW-1:0] A_STORE  = '0,
    parameter logic [AW-1:0] A_RECALL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  ev_e           ev,
    input  logic [AW-1:0] ev_addr,
    output logic          hit_store,
    output logic          hit_recall
);
    localparam logic [2:0] LAST_STEP = 3'd5;

    typedef struct packed {
        logic [2:0] step;
    } mq_t;

    mq_t mq_d, mq_q;

    function automatic logic [AW-1:0] pfx_at(input logic [2:0] idx);
        case (idx)
            3'd0:    return A1;
            3'd1:    return A2;
            3'd2:    return A3;
            3'd3:    return A4;
            default: return A5;
        endcase
    endfunction

    always_comb begin
        mq_d       = mq_q;
        hit_store  = 1'b0;
        hit_recall = 1'b0;
        if (!en) begin
            mq_d.step = 3'd0;
        end else if (ev == EV_WRITE) begin
            mq_d.step = 3'd0;
        end else if (ev == EV_READ) begin
            if (mq_q.step != 3'd0 && ev_addr == pfx_at(mq_q.step - 3'd1)) begin
                mq_d.step = 3'd0;                 // repeated read
            end else if (mq_q.step == LAST_STEP) begin
                mq_d.step = 3'd0;
                if (ev_addr == A_STORE) begin
                    hit_store = 1'b1;
                end else if (ev_addr == A_RECALL) begin
                    hit_recall = 1'b1;
                end else if (ev_addr == A1) begin
                    mq_d.step = 3'd1;
                end
            end else if (ev_addr == pfx_at(mq_q.step)) begin
                mq_d.step = mq_q.step + 3'd1;
            end else if (ev_addr == A1) begin
                mq_d.step = 3'd1;
            end else begin
                mq_d.step = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq_q <= '{step: 3'd0};
        end else begin
            mq_q <= mq_d;
        end
    end
endmodule

// File: rtl/nvsc_timer.sv
// Loadable down counter timing the autonomous copy cycles.
module nvsc_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tq_t;

    tq_t tq_d, tq_q;

    always_comb begin
        tq_d = tq_q;
        if (load) begin
            tq_d.cnt = load_val;
        end else if (tq_q.cnt != '0) begin
            tq_d.cnt = tq_q.cnt - CW'(1);
        end
    end

    assign zero = (tq_q.cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq_q <= '{cnt: '0};
        end else begin
            tq_q <= tq_d;
        end
    end
endmodule

// File: rtl/nvsc_ctrl.sv
module nvsc_ctrl
    import nvsc_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            MIN_LOW    = 4,
    parameter int            STORE_CYC  = 2_000_000,
    parameter int            RECALL_CYC = 4000,
    parameter logic [AW-1:0] A1         = AW'(16'h1A2B),
    parameter logic [AW-1:0] A2         = AW'(16'h2C4D),
    parameter logic [AW-1:0] A3         = AW'(16'h3E61),
    parameter logic [AW-1:0] A4         = AW'(16'h4F83),
    parameter logic [AW-1:0] A5         = AW'(16'h50A5),
    parameter logic [AW-1:0] A_STORE    = AW'(16'h61C7),
    parameter logic [AW-1:0] A_RECALL   = AW'(16'h72E9)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          supply_ok,
    output logic          store_start,
    output logic          recall_start,
    output logic          busy,
    output logic          dq_disable
);
    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYC - 1);

    typedef struct packed {
        md_e  mode;
        logic st_pulse;
        logic rc_pulse;
    } cq_t;

    cq_t           cq_d, cq_q;
    ev_e           ev;
    logic [AW-1:0] ev_addr;
    logic          hit_store, hit_recall;
    logic          tm_load, tm_zero;
    logic [CW-1:0] tm_val;

    nvsc_pulse #(.AW(AW), .MIN_LOW(MIN_LOW)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .ev      (ev),
        .ev_addr (ev_addr)
    );

    nvsc_match #(
        .AW(AW), .A1(A1), .A2(A2), .A3(A3), .A4(A4), .A5(A5),
        .A_STORE(A_STORE), .A_RECALL(A_RECALL)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cq_q.mode == MD_IDLE),
        .ev         (ev),
        .ev_addr    (ev_addr),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    nvsc_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .zero     (tm_zero)
    );

    always_comb begin
        cq_d          = cq_q;
        cq_d.st_pulse = 1'b0;
        cq_d.rc_pulse = 1'b0;
        tm_load       = 1'b0;
        tm_val        = '0;
        unique case (cq_q.mode)
            MD_PWR_WAIT: begin
                if (supply_ok) begin
                    cq_d.mode     = MD_RECALL;
                    cq_d.rc_pulse = 1'b1;
                    tm_load       = 1'b1;
                    tm_val        = RC_LOAD;
                end
            end
            MD_IDLE: begin
                if (hit_store) begin
                    cq_d.mode     = MD_STORE;
                    cq_d.st_pulse = 1'b1;
                    tm_load       = 1'b1;
                    tm_val        = ST_LOAD;
                end else if (hit_recall) begin
                    cq_d.mode     = MD_RECALL;
                    cq_d.rc_pulse = 1'b1;
                    tm_load       = 1'b1;
                    tm_val        = RC_LOAD;
                end
            end
            MD_STORE: begin
                if (!supply_ok || tm_zero) begin
                    cq_d.mode = MD_IDLE;
                end
            end
            MD_RECALL: begin
                if (tm_zero) begin
                    cq_d.mode = MD_IDLE;
                end
            end
            default: cq_d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq_q <= '{mode: MD_PWR_WAIT, st_pulse: 1'b0, rc_pulse: 1'b0};
        end else begin
            cq_q <= cq_d;
        end
    end

    assign store_start  = cq_q.st_pulse;
    assign recall_start = cq_q.rc_pulse;
    assign busy         = (cq_q.mode == MD_STORE) || (cq_q.mode == MD_RECALL);
    assign dq_disable   = (cq_q.mode != MD_IDLE);
endmodule

// File: rtl/nvsc_ctrl_chk.sv
module nvsc_ctrl_chk #(
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 4000
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic store_start,
    input logic recall_start,
    input logic busy,
    input logic dq_disable
);
    logic        seen_q;
    logic        op_store_q;
    logic [31:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            op_store_q <= 1'b0;
            run_cnt    <= '0;
        end else begin
            if (supply_ok) seen_q <= 1'b1;
            if (store_start || recall_start) begin
                op_store_q <= store_start;
                run_cnt    <= 32'd1;
            end else if (busy) begin
                run_cnt <= run_cnt + 32'd1;
            end
        end
    end

    a_r2_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_start, recall_start}));

    a_r2_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> !store_start);

    a_r2_recall_single: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start |=> !recall_start);

    a_r8_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        (store_start || recall_start) |-> busy);

    a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_start || recall_start));

    a_r10_recall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store_start && !recall_start && !op_store_q
         && (run_cnt + 32'd1) < 32'(RECALL_CYC)) |=> busy);

    a_r8_recall_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store_start && !recall_start && !op_store_q
         && (run_cnt + 32'd1) == 32'(RECALL_CYC)) |=> !busy);

    a_r8_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store_start && !recall_start && op_store_q
         && (run_cnt + 32'd1) == 32'(STORE_CYC)) |=> !busy);

    a_r10_store_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !supply_ok && (store_start || (op_store_q && !recall_start)))
        |=> !busy);

    a_r12_dq_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dq_disable);

    a_r11_pwr_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!busy && dq_disable && !store_start && !recall_start));
endmodule

bind nvsc_ctrl nvsc_ctrl_chk #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .store_start  (store_start),
    .recall_start (recall_start),
    .busy         (busy),
    .dq_disable   (dq_disable)
);

// File: tb/nvsc_ctrl_tb.sv
module nvsc_ctrl_tb;
    localparam int AW = 4;
    localparam int ML = 2;
    localparam int SC = 40;
    localparam int RC = 8;
    localparam logic [3:0] P1 = 4'd3, P2 = 4'd9, P3 = 4'd14, P4 = 4'd6, P5 = 4'd1;
    localparam logic [3:0] PST = 4'd15, PRC = 4'd12, NOADR = 4'd0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce_n = 1'b1, we_n = 1'b1, supply_ok = 1'b0;
    logic store_start, recall_start, busy, dq_disable;

    int checks = 0, errors = 0;
    logic seen_st = 1'b0, seen_rc = 1'b0;
    logic got_st, got_rc;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nvsc_ctrl #(
        .AW(AW), .MIN_LOW(ML), .STORE_CYC(SC), .RECALL_CYC(RC),
        .A1(P1), .A2(P2), .A3(P3), .A4(P4), .A5(P5), .A_STORE(PST), .A_RECALL(PRC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .supply_ok(supply_ok), .store_start(store_start), .recall_start(recall_start),
        .busy(busy), .dq_disable(dq_disable)
    );

    function automatic logic [3:0] pfx(input int i);
        case (i)
            0: return P1;
            1: return P2;
            2: return P3;
            3: return P4;
            default: return P5;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one chip-enable pulse with nlow low samples; wr pulls we_n low throughout
    task automatic acc(input logic [3:0] a, input int nlow, input bit wr);
        @(negedge clk);
        addr = a; ce_n = 1'b0; we_n = wr ? 1'b0 : 1'b1;
        repeat (nlow) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        got_st = store_start;
        got_rc = recall_start;
        seen_st = seen_st | got_st;
        seen_rc = seen_rc | got_rc;
    endtask

    task automatic rd(input logic [3:0] a);
        acc(a, ML, 1'b0);
    endtask

    task automatic prefix(input int nlow);
        for (int i = 0; i < 5; i++) acc(pfx(i), nlow, 1'b0);
    endtask

    task automatic clr();
        seen_st = 1'b0;
        seen_rc = 1'b0;
    endtask

    task automatic run_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 / R12: waiting for supply
        chk("R11 busy after reset", busy, 0);
        chk("R12 dq_disable before power-up", dq_disable, 1);
        clr();
        prefix(ML); rd(PST);
        chk("R11 pattern ignored before power-up", seen_st, 0);
        chk("R11 still idle-waiting", busy, 0);

        // R11: power-up recall
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R11 auto recall pulse", recall_start, 1);
        run_len(n);
        chk("R11 auto recall length", n, RC);
        chk("R12 dq_disable low when idle", dq_disable, 0);

        // R2 / R8: store
        prefix(ML); rd(PST);
        chk("R2 store pulse timing", got_st, 1);
        chk("R2 no recall with store", got_rc, 0);
        chk("R12 dq_disable during store", dq_disable, 1);
        @(negedge clk);
        chk("R2 store pulse one cycle", store_start, 0);
        run_len(n);
        chk("R8 store length", n + 1, SC);

        // R2 / R10: recall with supply low runs to the end
        prefix(ML);
        supply_ok = 1'b0;
        rd(PRC);
        chk("R2 recall pulse timing", got_rc, 1);
        run_len(n);
        chk("R10 recall not aborted", n, RC);
        supply_ok = 1'b1;

        // R10: store abort
        prefix(ML); rd(PST);
        chk("R10 store started", got_st, 1);
        repeat (3) @(negedge clk);
        chk("R10 busy before drop", busy, 1);
        supply_ok = 1'b0;
        @(negedge clk);
        chk("R10 store aborted", busy, 0);
        chk("R12 dq_disable after abort", dq_disable, 0);
        supply_ok = 1'b1;

        // R1: long pulses count
        clr();
        prefix(5); acc(PST, 5, 1'b0);
        chk("R1 long pulses count", seen_st, 1);
        run_len(n);

        // R2 / R3: sweep the sixth address
        for (int v = 0; v < 16; v++) begin
            clr();
            prefix(ML); rd(4'(v));
            chk($sformatf("R2 sixth=%0d store", v), seen_st, (v == int'(PST)) ? 1 : 0);
            chk($sformatf("R3 sixth=%0d recall", v), seen_rc, (v == int'(PRC)) ? 1 : 0);
            run_len(n);
            acc(NOADR, ML, 1'b1);
        end
        // R3: discarded pattern followed by a full one
        clr();
        prefix(ML); rd(4'd7); prefix(ML); rd(PST);
        chk("R3 pattern after discard", seen_st, 1);
        run_len(n);

        // R4: mismatch at each position
        for (int p = 0; p < 5; p++) begin
            clr();
            for (int i = 0; i < 5; i++) rd(i == p ? NOADR : pfx(i));
            rd(PST);
            chk($sformatf("R4 mismatch at step %0d", p + 1), seen_st, 0);
            acc(NOADR, ML, 1'b1);
        end
        // R4: first address restarts as step one
        clr();
        rd(P1); rd(P2); prefix(ML); rd(PST);
        chk("R4 restart as step one", seen_st, 1);
        run_len(n);

        // R5: repeated read at each position
        for (int p = 1; p <= 5; p++) begin
            clr();
            for (int i = 0; i < p; i++) rd(pfx(i));
            rd(pfx(p - 1));
            for (int i = p; i < 5; i++) rd(pfx(i));
            rd(PST);
            chk($sformatf("R5 repeat after step %0d", p), seen_st, 0);
            acc(NOADR, ML, 1'b1);
        end

        // R6: write breaks the pattern
        clr();
        rd(P1); rd(P2); acc(P3, ML, 1'b1); rd(P3); rd(P4); rd(P5); rd(PST);
        chk("R6 write resets", seen_st, 0);
        acc(NOADR, ML, 1'b1);

        // R7: short pulses ignored
        clr();
        rd(P1); rd(P2); acc(NOADR, ML - 1, 1'b0); rd(P3); rd(P4); rd(P5); rd(PST);
        chk("R7 short pulse leaves detector", seen_st, 1);
        run_len(n);
        clr();
        rd(P1); rd(P2); acc(P3, ML - 1, 1'b0); rd(P4); rd(P5); rd(PST);
        chk("R7 short pulse not a step", seen_st, 0);
        acc(NOADR, ML, 1'b1);

        // R9: bus ignored while busy, detector cleared
        prefix(ML); rd(PST);
        clr();
        prefix(ML); rd(PRC);
        chk("R9 busy held during accesses", busy, 1);
        chk("R9 no start while busy", seen_rc, 0);
        run_len(n);
        clr();
        rd(PRC);
        chk("R9 detector at start after busy", seen_rc, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule